// File: doc/BRIEF.md
# Paddle Game Session Controller

This block runs one player's session of a ball-and-paddle video game. After reset it asks for the rules text and keeps the graphics frozen until either player button is pressed. During play it counts paddle hits into a decimal score and counts missed balls against a fixed ball budget. After each miss it holds a timed pause before the next ball. When the last ball is lost it shows the game-over text.

The pause is timed in video frames, using a one-cycle tick per frame. At 60 frames per second the default of 120 ticks gives two seconds. The score leaves the block as packed BCD digits and the ball count as a small binary number. The pixel path can draw both at the top of the screen. The still-graphics output tells the graphics engine to park the paddle in the middle of the screen and stop the ball. This output is high in every state except play.

From game over, a button press is accepted only once the pause timer has run out. The press leads to a ready state that shows no rules text. The next press starts a fresh session.

Top module: `paddle_session_ctrl`

## Requirements
- R1: After reset, the following hold: the rules overlay is on, the game-over overlay is off, the still-graphics output is high, the score is 00 and the ball count is 3.
- R2: In the rules state or the ready state, a press of either button starts a session at the next clock edge. At that edge the still-graphics output drops, the rules overlay turns off, the score becomes 00 and the ball count becomes 3.
- R3: A hit pulse during play adds one to the score at the next clock edge. A hit pulse in any other state leaves the score unchanged.
- R4: The score is packed BCD: bits [3:0] hold the ones digit and bits [7:4] hold the tens digit. Each digit stays within 0 to 9. The ones digit carries into the tens digit when it steps from 9, and 99 steps to 00.
- R5: A miss pulse during play lowers the ball count by one and raises the still-graphics output at the next edge. A miss pulse in any other state changes nothing.
- R6: After a miss that leaves balls in hand, play resumes only after 120 frame ticks. The 120th tick empties the timer at one edge, and the still-graphics output drops at the following edge.
- R7: A miss that takes the ball count from 1 to 0 enters game over. At the next edge the game-over overlay turns on, and it stays on until R8 lets it go.
- R8: In game over, button presses are ignored until the 120-tick timer has run out. A press after that moves to the ready state. In the ready state both overlays are off, the still-graphics output stays high, and the score is kept.
- R9: A hit pulse and a miss pulse in the same play cycle both take effect: the score goes up by one and the ball count goes down by one.
- R10: The rules overlay and the game-over overlay are never on together. Neither is on during play or during a pause.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_left | input | 1 | First player button, already debounced, active high |
| btn_right | input | 1 | Second player button, already debounced, active high |
| hit_pulse | input | 1 | One-cycle pulse when the paddle strikes the ball |
| miss_pulse | input | 1 | Pulse when the ball reaches the right border |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| gfx_freeze | output | 1 | Still-graphics control: high outside play |
| show_rules | output | 1 | Rules text overlay select |
| show_over | output | 1 | Game-over text overlay select |
| score_bcd | output | 8 | Score, packed BCD, ones digit in [3:0] |
| balls_left | output | 2 | Balls remaining, 0 to 3 |

## Verification
A hit and a miss can fall in the same play cycle. The score counter and the ball budget must then both act on that one edge, while the state machine leaves play. The bench provokes this by driving both pulses in the same cycle. It then checks, at the next edge, that the score has gone up by one, that the ball count has gone down by one and that the graphics are frozen. A pulse of either kind in the following pause cycle must change nothing.

// File: rtl/paddle_session_pkg.sv
package paddle_session_pkg;

  typedef enum logic [2:0] {
    ST_RULES = 3'd0,
    ST_READY = 3'd1,
    ST_PLAY  = 3'd2,
    ST_PAUSE = 3'd3,
    ST_OVER  = 3'd4
  } sess_state_t;

  localparam logic [3:0] BCD_MAX = 4'd9;

  // next value of one decimal digit
  function automatic logic [3:0] bcd_step(input logic [3:0] d);
    return (d >= BCD_MAX) ? 4'd0 : d + 4'd1;
  endfunction

  // digit rolls over on this step
  function automatic logic bcd_rolls(input logic [3:0] d);
    return (d >= BCD_MAX);
  endfunction

endpackage

// File: rtl/bcd_score_counter.sv
module bcd_score_counter #(
  parameter int NUM_DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    inc,
  output logic [NUM_DIGITS*4-1:0] digits
);
  import paddle_session_pkg::*;

  logic [NUM_DIGITS:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic [3:0] d_q;
    assign carry[i+1] = carry[i] & bcd_rolls(d_q);
    assign digits[i*4 +: 4] = d_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) d_q <= 4'd0;
      else if (carry[i]) d_q <= bcd_step(d_q);
    end
  end

endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int PAUSE_TICKS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(PAUSE_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (start) cnt_q <= CW'(PAUSE_TICKS);
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/ball_budget.sv
module ball_budget #(
  parameter int BALLS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reload,
  input  logic                         take,
  output logic [$clog2(BALLS+1)-1:0]   left,
  output logic                         last
);
  localparam int BW = $clog2(BALLS + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || reload) cnt_q <= BW'(BALLS);
    else if (take && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign left = cnt_q;
  assign last = (cnt_q == BW'(1));

endmodule

// File: rtl/session_fsm.sv
module session_fsm (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            any_btn,
  input  logic                            hit,
  input  logic                            miss,
  input  logic                            timer_done,
  input  logic                            last_ball,
  output paddle_session_pkg::sess_state_t state,
  output logic                            sess_start,
  output logic                            score_inc,
  output logic                            ball_take,
  output logic                            timer_start
);
  import paddle_session_pkg::*;

  sess_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    sess_start  = 1'b0;
    score_inc   = 1'b0;
    ball_take   = 1'b0;
    timer_start = 1'b0;
    unique case (state_q)
      ST_RULES, ST_READY: begin
        if (any_btn) begin
          sess_start = 1'b1;
          state_d    = ST_PLAY;
        end
      end
      ST_PLAY: begin
        score_inc = hit;
        if (miss) begin
          ball_take   = 1'b1;
          timer_start = 1'b1;
          state_d     = last_ball ? ST_OVER : ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (timer_done) state_d = ST_PLAY;
      end
      ST_OVER: begin
        if (timer_done && any_btn) state_d = ST_READY;
      end
      default: state_d = ST_RULES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RULES;
    else state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/paddle_session_ctrl.sv
module paddle_session_ctrl #(
  parameter int NUM_DIGITS  = 2,
  parameter int BALLS       = 3,
  parameter int PAUSE_TICKS = 120
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       btn_left,
  input  logic                       btn_right,
  input  logic                       hit_pulse,
  input  logic                       miss_pulse,
  input  logic                       frame_tick,
  output logic                       gfx_freeze,
  output logic                       show_rules,
  output logic                       show_over,
  output logic [NUM_DIGITS*4-1:0]    score_bcd,
  output logic [$clog2(BALLS+1)-1:0] balls_left
);
  import paddle_session_pkg::*;

  sess_state_t state;
  logic any_btn, last_ball;

  // named events, observed by the checker
  logic start_evt, hit_evt, miss_evt, timer_done;
  logic in_play, in_pause, in_over;

  assign any_btn = btn_left | btn_right;

  session_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_btn     (any_btn),
    .hit         (hit_pulse),
    .miss        (miss_pulse),
    .timer_done  (timer_done),
    .last_ball   (last_ball),
    .state       (state),
    .sess_start  (start_evt),
    .score_inc   (hit_evt),
    .ball_take   (miss_evt),
    .timer_start ()
  );

  pause_timer #(.PAUSE_TICKS(PAUSE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (miss_evt),
    .tick  (frame_tick),
    .done  (timer_done)
  );

  bcd_score_counter #(.NUM_DIGITS(NUM_DIGITS)) u_score (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_evt),
    .inc    (hit_evt),
    .digits (score_bcd)
  );

  ball_budget #(.BALLS(BALLS)) u_balls (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (start_evt),
    .take   (miss_evt),
    .left   (balls_left),
    .last   (last_ball)
  );

  assign in_play    = (state == ST_PLAY);
  assign in_pause   = (state == ST_PAUSE);
  assign in_over    = (state == ST_OVER);
  assign gfx_freeze = ~in_play;
  assign show_rules = (state == ST_RULES);
  assign show_over  = in_over;

endmodule

// File: rtl/paddle_session_ctrl_chk.sv
module paddle_session_ctrl_chk #(
  parameter int NUM_DIGITS = 2,
  parameter int BALLS      = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_evt,
  input logic                       hit_evt,
  input logic                       miss_evt,
  input logic                       timer_done,
  input logic                       in_play,
  input logic                       in_pause,
  input logic                       in_over,
  input logic                       gfx_freeze,
  input logic                       show_rules,
  input logic                       show_over,
  input logic [NUM_DIGITS*4-1:0]    score_bcd,
  input logic [$clog2(BALLS+1)-1:0] balls_left
);
  localparam int BW = $clog2(BALLS + 1);

  function automatic int modulus();
    int m = 1;
    for (int i = 0; i < NUM_DIGITS; i++) m = m * 10;
    return m;
  endfunction

  function automatic int as_int(input logic [NUM_DIGITS*4-1:0] s);
    int v = 0;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) v = v * 10 + int'(s[i*4 +: 4]);
    return v;
  endfunction

  function automatic logic digits_ok(input logic [NUM_DIGITS*4-1:0] s);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (s[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!gfx_freeze && score_bcd == '0 && balls_left == BW'(BALLS)));

  assert_hit_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (as_int(score_bcd) == (as_int($past(score_bcd)) + 1) % modulus()));

  assert_score_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_play && !start_evt) |=> $stable(score_bcd));

  assert_bcd_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(score_bcd));

  assert_miss_takes_ball_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (gfx_freeze && balls_left == $past(balls_left) - BW'(1)));

  assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pause && !timer_done) |=> in_pause);

  assert_last_miss_over_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && balls_left == BW'(1)) |=> show_over);

  assert_over_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_over && !timer_done) |=> in_over);

  assert_overlay_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({show_rules, show_over}));

  assert_no_overlay_in_play_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_play || in_pause) |-> (!show_rules && !show_over));

endmodule

bind paddle_session_ctrl paddle_session_ctrl_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .BALLS     (BALLS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_evt  (start_evt),
  .hit_evt    (hit_evt),
  .miss_evt   (miss_evt),
  .timer_done (timer_done),
  .in_play    (in_play),
  .in_pause   (in_pause),
  .in_over    (in_over),
  .gfx_freeze (gfx_freeze),
  .show_rules (show_rules),
  .show_over  (show_over),
  .score_bcd  (score_bcd),
  .balls_left (balls_left)
);

// File: tb/paddle_session_ctrl_test.sv
module paddle_session_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_left = 1'b0, btn_right = 1'b0;
  logic hit_pulse = 1'b0, miss_pulse = 1'b0, frame_tick = 1'b0;
  logic gfx_freeze, show_rules, show_over;
  logic [7:0] score_bcd;
  logic [1:0] balls_left;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  paddle_session_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_left   (btn_left),
    .btn_right  (btn_right),
    .hit_pulse  (hit_pulse),
    .miss_pulse (miss_pulse),
    .frame_tick (frame_tick),
    .gfx_freeze (gfx_freeze),
    .show_rules (show_rules),
    .show_over  (show_over),
    .score_bcd  (score_bcd),
    .balls_left (balls_left)
  );

  // {btn, hit, miss, freeze, rules, over, score[7:0], balls[1:0]}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 2'd3}, // R3 hit in rules ignored
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 2'd3}, // R5 miss in rules ignored
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd3}, // R2 start
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 2'd3}, // R3
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 2'd3}, // R3
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 2'd3}, // R3 idle
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 2'd2}, // R9 hit+miss
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 2'd2}, // R3 hit in pause
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 2'd2}  // R5 miss in pause
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic bl, input logic br, input logic h,
                     input logic m, input logic t);
    btn_left = bl; btn_right = br; hit_pulse = h; miss_pulse = m; frame_tick = t;
    @(posedge clk);
    #2;
    btn_left = 0; btn_right = 0; hit_pulse = 0; miss_pulse = 0; frame_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0);
    end
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check("R1 rules", show_rules, 1);
    check("R1 over", show_over, 0);
    check("R1 freeze", gfx_freeze, 1);
    check("R1 score", score_bcd, 8'h00);
    check("R1 balls", balls_left, 3);

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][15], 1'b0, VEC[v][14], VEC[v][13], 1'b0);
      check($sformatf("vec%0d freeze", v), gfx_freeze, VEC[v][12]);
      check($sformatf("vec%0d rules R10", v), show_rules, VEC[v][11]);
      check($sformatf("vec%0d over R10", v), show_over, VEC[v][10]);
      check($sformatf("vec%0d score", v), score_bcd, VEC[v][9:2]);
      check($sformatf("vec%0d balls", v), balls_left, VEC[v][1:0]);
    end

    // R6 exact pause length
    ticks(119);
    check("R6 still paused after 119", gfx_freeze, 1);
    cyc(0, 0, 0, 0, 1);
    check("R6 paused at 120th tick edge", gfx_freeze, 1);
    cyc(0, 0, 0, 0, 0);
    check("R6 play resumes", gfx_freeze, 0);

    // R4 carry and wrap, from 03
    hits(6);
    check("R4 ones at 9", score_bcd, 8'h09);
    hits(1);
    check("R4 carry to tens", score_bcd, 8'h10);
    hits(89);
    check("R4 reach 99", score_bcd, 8'h99);
    hits(1);
    check("R4 wrap 99->00", score_bcd, 8'h00);
    hits(2);

    // R5 second miss
    cyc(0, 0, 0, 1, 0);
    check("R5 balls", balls_left, 1);
    check("R5 freeze", gfx_freeze, 1);
    ticks(120);
    cyc(0, 0, 0, 0, 0);
    check("R6 second resume", gfx_freeze, 0);

    // R7 last miss
    cyc(0, 0, 0, 1, 0);
    check("R7 over on", show_over, 1);
    check("R7 balls zero", balls_left, 0);
    check("R7 freeze", gfx_freeze, 1);
    cyc(0, 1, 0, 0, 0);
    check("R8 early press ignored", show_over, 1);
    ticks(120);
    cyc(0, 0, 0, 0, 0);
    check("R8 still over without press", show_over, 1);
    cyc(0, 1, 0, 0, 0);
    check("R8 ready over off", show_over, 0);
    check("R8 ready rules off", show_rules, 0);
    check("R8 ready freeze", gfx_freeze, 1);
    check("R8 score kept", score_bcd, 8'h02);
    cyc(0, 0, 1, 0, 0);
    check("R3 hit in ready ignored", score_bcd, 8'h02);

    // R2 restart from ready
    cyc(0, 1, 0, 0, 0);
    check("R2 restart play", gfx_freeze, 0);
    check("R2 score cleared", score_bcd, 8'h00);
    check("R2 balls reloaded", balls_left, 3);
    check("R10 no overlay in play", show_rules | show_over, 0);

    // R1 reset mid-session
    hits(3);
    rst_n = 1'b0;
    cyc(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    check("R1 rules after reset", show_rules, 1);
    check("R1 score after reset", score_bcd, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule